// File: doc/BRIEF.md
# Triggered One-Shot Pulse Timer

This block is a 16-bit up-counting timer that produces one delayed pulse per trigger on three compare outputs. While enabled and idle, the counter rests at all-ones. A trigger arrives either as a software start strobe or as a selected edge on an external trigger pin. Once triggered, the counter advances on each count tick and wraps from all-ones to zero on its first step.

Each of channels 1 to 3 raises its own pulse output when the count reaches that channel's compare value. Channel 0 marks the end of the shot. On its match, all three pulse outputs fall together, the counter clears to zero and stops, and a separate toggle output flips. Triggers that arrive during a shot are dropped. A new shot may start from the stopped-at-zero state.

Compare values come in on a valid/ready register write port. The port never applies back-pressure: `wr_ready` is always high, and a beat is taken on every clock edge where `wr_valid` is high. A written value first lands in the channel's holding register. It moves into the comparison buffer on the following edge. Writes are allowed at any time, including during a shot.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: While `enable` is low, `count` is 16'hFFFF, `running`, `pulse_out` and `tog_out` are low, and a trigger of either kind does not start the counter.
- R2: With `enable` high and the counter idle at 16'hFFFF, a `sw_start` pulse sets `running` on the next clock edge with `count` still 16'hFFFF; the first tick after that makes `count` 16'h0000.
- R3: `edge_sel` picks the external trigger: 2'b00 none, 2'b01 rising, 2'b10 falling, 2'b11 both. `trig_in` passes through a two-flop synchronizer, so a change set up before edge P0 sets `running` at edge P2.
- R4: While running, `count` rises by one on each clock edge where `tick` is high and holds where `tick` is low.
- R5: `pulse_out[k-1]` (k = 1..3) goes high on the clock edge after `count` equals channel k's buffered compare value, and stays high until the channel 0 match.
- R6: On the clock edge after `count` equals channel 0's buffered value, `count` becomes 16'h0000, `running` goes low and all `pulse_out` bits go low.
- R7: `tog_out` inverts at each channel 0 match. It is 0 after reset and is cleared while `enable` is low.
- R8: A trigger that arrives while running has no effect on `count` or on when the shot ends. From the stopped state at 16'h0000, a trigger sets `running` on the next edge, and the next tick makes `count` 16'h0001.
- R9: `wr_ready` is always 1. A beat with `wr_valid` high stores `wr_data` into the register of channel `wr_chan` (0..3) on that edge, and the channel's comparison buffer takes the value on the following edge.
- R10: After reset, `count` is 16'hFFFF, all outputs except `wr_ready` are low, and all compare registers and buffers are 16'h0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Timer enable; low forces idle |
| tick | input | 1 | Count-enable tick |
| sw_start | input | 1 | Software start strobe |
| trig_in | input | 1 | External trigger pin (asynchronous) |
| edge_sel | input | 2 | Trigger edge select: 00 none, 01 rise, 10 fall, 11 both |
| wr_valid | input | 1 | Compare write beat valid |
| wr_ready | output | 1 | Compare write ready (always 1) |
| wr_chan | input | 2 | Compare channel addressed by the write |
| wr_data | input | 16 | Compare value to write |
| count | output | 16 | Current counter value |
| running | output | 1 | High while a shot is in progress |
| pulse_out | output | 3 | Pulse outputs of channels 1 to 3 |
| tog_out | output | 1 | Toggles on each channel 0 match |

## Verification
Several rules are checked by assertions on every cycle: the forced idle state while disabled, the single-step increment gated by tick, that a shot starts only from all-ones or zero, that the stop lands on zero with the pulses cleared, that pulse bits fall only when the shot ends, and that the toggle output changes only at a stop. Other behaviour can only be shown by the bench's scenarios: the exact edge on which each pulse rises relative to its compare value, the two-cycle buffer transfer after a write, the synchronizer delay and the effect of each edge-select code, and that a retrigger during a shot leaves its timeline unchanged.

// File: rtl/ospt_pkg.sv
package ospt_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/ospt_trig_detect.sv
module ospt_trig_detect
  import ospt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  input  logic [1:0] edge_sel,
  output logic       edge_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;
  edge_mode_e             mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign cur  = sync_q[SYNC_STAGES-1];
  assign mode = edge_mode_e'(edge_sel);

  always_comb begin
    unique case (mode)
      EDGE_RISE: edge_hit = cur & ~prev_q;
      EDGE_FALL: edge_hit = ~cur & prev_q;
      EDGE_BOTH: edge_hit = cur ^ prev_q;
      default:   edge_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/ospt_cmp_bank.sv
module ospt_cmp_bank #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_valid,
  input  logic [CH_W-1:0]            wr_chan,
  input  logic [CNT_W-1:0]           wr_data,
  output logic [N_CH-1:0][CNT_W-1:0] cmp_buf
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] hold_q;
    logic [CNT_W-1:0] buf_q;
    logic             xfer_q;
    logic             sel;

    assign sel = wr_valid && (wr_chan == CH_W'(ch));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= '0;
        buf_q  <= '0;
        xfer_q <= 1'b0;
      end else begin
        xfer_q <= sel;
        if (sel)    hold_q <= wr_data;
        if (xfer_q) buf_q  <= hold_q;
      end
    end

    assign cmp_buf[ch] = buf_q;
  end
endmodule

// File: rtl/ospt_core.sv
module ospt_core #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 4,
  localparam int N_OUT = N_CH - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       tick,
  input  logic                       start,
  input  logic [N_CH-1:0][CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0]           count,
  output logic                       running,
  output logic [N_OUT-1:0]           pulse_out,
  output logic                       tog_out
);
  localparam logic [CNT_W-1:0] IDLE_VAL = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [N_OUT-1:0] pulse_q;
  logic             tog_q;
  logic [N_CH-1:0]  hit;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_match
    assign hit[ch] = run_q && (cnt_q == cmp_buf[ch]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= IDLE_VAL;
      run_q   <= 1'b0;
      pulse_q <= '0;
      tog_q   <= 1'b0;
    end else if (!enable) begin
      cnt_q   <= IDLE_VAL;
      run_q   <= 1'b0;
      pulse_q <= '0;
      tog_q   <= 1'b0;
    end else if (hit[0]) begin
      cnt_q   <= '0;
      run_q   <= 1'b0;
      pulse_q <= '0;
      tog_q   <= ~tog_q;
    end else begin
      if (!run_q && start)    run_q <= 1'b1;
      else if (run_q && tick) cnt_q <= cnt_q + CNT_W'(1);
      pulse_q <= pulse_q | hit[N_CH-1:1];
    end
  end

  assign count     = cnt_q;
  assign running   = run_q;
  assign pulse_out = pulse_q;
  assign tog_out   = tog_q;
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer #(
  parameter int CNT_W       = 16,
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W  = $clog2(N_CH),
  localparam int N_OUT = N_CH - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic             sw_start,
  input  logic             trig_in,
  input  logic [1:0]       edge_sel,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic [N_OUT-1:0] pulse_out,
  output logic             tog_out
);
  logic                       edge_hit;
  logic                       start;
  logic [N_CH-1:0][CNT_W-1:0] cmp_buf;

  assign wr_ready = 1'b1;

  ospt_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_in  (trig_in),
    .edge_sel (edge_sel),
    .edge_hit (edge_hit)
  );

  ospt_cmp_bank #(.CNT_W(CNT_W), .N_CH(N_CH)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid && wr_ready),
    .wr_chan  (wr_chan),
    .wr_data  (wr_data),
    .cmp_buf  (cmp_buf)
  );

  assign start = enable && (sw_start || edge_hit);

  ospt_core #(.CNT_W(CNT_W), .N_CH(N_CH)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .start     (start),
    .cmp_buf   (cmp_buf),
    .count     (count),
    .running   (running),
    .pulse_out (pulse_out),
    .tog_out   (tog_out)
  );
endmodule

// File: rtl/ospt_checker.sv
module ospt_checker #(
  parameter int CNT_W = 16,
  parameter int N_OUT = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic [N_OUT-1:0] pulse_out,
  input logic             tog_out
);
  localparam logic [CNT_W-1:0] IDLE_VAL = '1;

  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (count == IDLE_VAL && !running && pulse_out == '0 && !tog_out));

  assert_step_by_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running && $past(tick)) |-> (count == $past(count) + CNT_W'(1)));

  assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && running && !$past(tick)) |-> $stable(count));

  assert_start_from_rest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(count) == IDLE_VAL || $past(count) == '0));

  assert_stop_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(running) && enable) |-> (count == '0 && pulse_out == '0));

  for (genvar i = 0; i < N_OUT; i++) begin : g_pulse
    assert_pulse_falls_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pulse_out[i]) |-> !running);
  end

  assert_toggle_only_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(tog_out)) |-> $fell(running));
endmodule

bind oneshot_pulse_timer ospt_checker #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .tick      (tick),
  .count     (count),
  .running   (running),
  .pulse_out (pulse_out),
  .tog_out   (tog_out)
);

// File: tb/test_oneshot_pulse_timer.sv
module test_oneshot_pulse_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        tick = 1'b0;
  logic        sw_start = 1'b0;
  logic        trig_in = 1'b0;
  logic [1:0]  edge_sel = 2'b00;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_chan = 2'b00;
  logic [15:0] wr_data = 16'h0;
  logic [15:0] count;
  logic        running;
  logic [2:0]  pulse_out;
  logic        tog_out;

  int n_chk  = 0;
  int n_fail = 0;
  logic exp_tog = 1'b0;
  int   cv [4];

  always #4 clk = ~clk;

  oneshot_pulse_timer i_oneshot_pulse_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .sw_start(sw_start),
    .trig_in(trig_in), .edge_sel(edge_sel), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_chan(wr_chan), .wr_data(wr_data), .count(count), .running(running),
    .pulse_out(pulse_out), .tog_out(tog_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clk_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] ch, input logic [15:0] val);
    wr_valid = 1'b1; wr_chan = ch; wr_data = val;
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
    cv[ch] = int'(val);
  endtask

  task automatic wait_stop(input string tag);
    int guard = 0;
    while (running && guard < 200) begin @(negedge clk); guard++; end
    chk({tag, " shot ends"}, running, 1'b0);
    exp_tog = ~exp_tog;
    chk({tag, " R7 toggle"}, tog_out, exp_tog);
  endtask

  // one full shot started by sw_start; from_idle=1 when counter is at FFFF
  task automatic run_shot(input string tag, input int from_idle, input int retrig);
    int o = from_idle;
    int last = cv[0] + o;
    logic [15:0] e_cnt;
    logic [2:0]  e_pul;
    sw_start = 1'b1;
    @(negedge clk);
    for (int j = 0; j <= last + 1; j++) begin
      sw_start = 1'b0;
      if (j <= last) e_cnt = (o == 1 && j == 0) ? 16'hFFFF : 16'(j - o);
      else           e_cnt = 16'h0000;
      for (int k = 1; k <= 3; k++)
        e_pul[k-1] = (j >= cv[k] + 1 + o) && (j <= last);
      chk($sformatf("%s R4/R8 count j=%0d", tag, j), count, e_cnt);
      chk($sformatf("%s R5 pulses j=%0d", tag, j), pulse_out, e_pul);
      chk($sformatf("%s R6 running j=%0d", tag, j), running, j <= last);
      if (j == retrig) sw_start = 1'b1;
      @(negedge clk);
    end
    sw_start = 1'b0;
    exp_tog = ~exp_tog;
    chk({tag, " R7 toggle after stop"}, tog_out, exp_tog);
  endtask

  task automatic t_reset;
    chk("R10 count idle", count, 16'hFFFF);
    chk("R10 running", running, 1'b0);
    chk("R10 pulses", pulse_out, 3'b000);
    chk("R10 toggle", tog_out, 1'b0);
    chk("R9 ready", wr_ready, 1'b1);
    sw_start = 1'b1; clk_n(1); sw_start = 1'b0; clk_n(2);
    chk("R1 start ignored while off", running, 1'b0);
    chk("R1 count held while off", count, 16'hFFFF);
  endtask

  task automatic t_first_shot;
    wr(2'd1, 16'd3); wr(2'd2, 16'd5); wr(2'd3, 16'd7); wr(2'd0, 16'd10);
    enable = 1'b1; tick = 1'b1;
    clk_n(2);
    chk("R1 enabled idle", count, 16'hFFFF);
    run_shot("R2 first shot", 1, -1);
  endtask

  task automatic t_retrigger;
    run_shot("R8 retrigger", 0, 4);
  endtask

  task automatic t_tick_gate;
    tick = 1'b0;
    sw_start = 1'b1; clk_n(1); sw_start = 1'b0;
    chk("R8 start from zero", running, 1'b1);
    clk_n(3);
    chk("R4 hold without tick", count, 16'h0000);
    tick = 1'b1; clk_n(1); tick = 1'b0;
    chk("R4 single tick", count, 16'h0001);
    clk_n(2);
    chk("R4 hold after tick", count, 16'h0001);
    tick = 1'b1;
    wait_stop("R4 gated");
  endtask

  task automatic t_rewrite;
    wr(2'd1, 16'd6); wr(2'd3, 16'd2);
    run_shot("R9 rewritten", 0, -1);
  endtask

  task automatic ext_try(input string tag, input logic [1:0] sel, input logic lvl, input logic expect_go);
    edge_sel = sel;
    trig_in = lvl;
    clk_n(2);
    if (expect_go) chk({tag, " R3 not before sync"}, running, 1'b0);
    clk_n(1);
    chk({tag, " R3 start"}, running, expect_go);
    if (expect_go) wait_stop(tag);
    else clk_n(3);
  endtask

  task automatic t_external;
    ext_try("rise/sel01", 2'b01, 1'b1, 1'b1);
    ext_try("fall/sel01", 2'b01, 1'b0, 1'b0);
    ext_try("rise/sel10", 2'b10, 1'b1, 1'b0);
    ext_try("fall/sel10", 2'b10, 1'b0, 1'b1);
    ext_try("rise/sel11", 2'b11, 1'b1, 1'b1);
    ext_try("fall/sel11", 2'b11, 1'b0, 1'b1);
    ext_try("rise/sel00", 2'b00, 1'b1, 1'b0);
    trig_in = 1'b0; clk_n(3);
  endtask

  task automatic t_disable;
    sw_start = 1'b1; clk_n(1); sw_start = 1'b0;
    clk_n(9);
    chk("R1 pulse up before disable", pulse_out[2], 1'b1);
    enable = 1'b0; clk_n(1);
    exp_tog = 1'b0;
    chk("R1 count forced idle", count, 16'hFFFF);
    chk("R1 running cleared", running, 1'b0);
    chk("R1 pulses cleared", pulse_out, 3'b000);
    chk("R1/R7 toggle cleared", tog_out, 1'b0);
    edge_sel = 2'b11; trig_in = 1'b1; clk_n(5);
    chk("R1 edge ignored while off", running, 1'b0);
    trig_in = 1'b0; clk_n(4);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clk_n(3);
    rst_n = 1'b1;
    clk_n(1);
    t_reset();
    t_first_shot();
    t_retrigger();
    t_tick_gate();
    t_rewrite();
    t_external();
    t_disable();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule